// File: doc/BRIEF.md
# Parallel Display Bus Transmitter

A register-programmed engine that moves command and pixel data between a host and a display module over a narrow parallel bus. The host, or a DMA engine, pushes 32-bit words (or 8-bit and 16-bit pieces of them, marked by byte strobes) into an eight-entry queue through a FIFO register. The engine cuts each word into bus beats of a programmed lane width. For each beat it drives an active-low write or read strobe. The strobe is held active for a programmed number of ticks and then released for a programmed rest time. A tick is the clock divided by 1 to 8.

Software selects command or data mode, asserts chip select and the run control, and loads the number of beats minus one. The engine issues exactly that many beats and then reports itself idle. In read direction the engine samples the bus at the end of each active phase, packs the samples into words and queues them for the host to read back. An identification register answers a write of zero with a fixed check sequence, so that software can confirm the block is present.

Top module: `pdisp_tx`

Register word addresses: 0 identification, 1 beat count, 2 timing, 3 control/status, 4 lane layout, 5 FIFO.

## Requirements
- R1: After reset, chip select, write strobe and read strobe are high, the DMA request is low, and control/status reads 0x10C (chip-select bit 2 = 1, run bit 3 = 1, idle bit 8 = 1).
- R2: After a write of 0 to the identification register, the next four reads of it return 0x55555555, 0xAAAAAAAA, the component code, and then the version word (major in bits 31:16, minor in bits 15:0).
- R3: The timing register holds the active width minus one in bits 3:0, the rest width minus one in bits 13:8, and the divider minus one in bits 18:16. Each strobe stays low for exactly (active)·(divider) clocks. Two strobes are at least (rest)·(divider) clocks apart, and the bus data holds steady while the strobe is low.
- R4: The lane layout register holds the lane width minus one in bits 4:0 and the lane count minus one in bits 9:5. With width 8 and count 4, a word goes out as four 8-bit beats. With width 16 and count 2, it goes out as two 16-bit beats. The least significant lane goes first.
- R5: When control bit 7 (swap) is set, lanes go out most significant first.
- R6: A lane whose first byte was not written (byte strobe low on push) is skipped, and it does not count as a beat.
- R7: The beat count register bits 17:0 hold beats minus one. After that many beats the engine stops strobing, even if words remain queued, and those words stay readable.
- R8: Chip select follows control bit 2 (active low). Command/data follows control bit 4 (1 = data). The bus is driven while the chip is selected in write direction.
- R9: Control bit 8 reads 0 while a transfer is in progress and 1 once it has finished.
- R10: If a transfer starts with a rest width below 3 ticks, the block resets itself. The queue is flushed and no strobe is issued.
- R11: With control bit 5 set, beats use the read strobe. Bus input sampled at the end of each active phase is packed least significant lane first, and the packed words are read back through the FIFO register.
- R12: The DMA request is high when control bits 0 (enable) and 6 (DMA mode) are set, the direction is write, and the queue is not full. The queue holds 8 words.
- R13: Writing control bit 1 flushes the queue. With enable (bit 0) clear, no strobe is issued and the DMA request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write |
| reg_re_i | input | 1 | Register read (has side effects on the FIFO and identification registers) |
| reg_addr_i | input | 3 | Register word address |
| reg_be_i | input | 4 | Byte strobes for FIFO pushes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_dc_o | output | 1 | Command (0) / data (1) select |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_oe_o | output | 1 | Bus drive enable |
| bus_dout_o | output | BUS_W | Bus output data |
| bus_din_i | input | BUS_W | Bus input data |
| dma_req_o | output | 1 | DMA request |

## Verification
On every cycle, the assertions check the bus rules. The two strobes are never low together, and neither is low without chip select. Output data holds while the write strobe is low. The queue never exceeds its depth and is empty after a flush. The DMA request never appears with a full queue, and the engine finishes only with its beat counter at zero. The bench scenarios cover the rest. These are the data content and order of beats under each lane layout and the swap bit, lane skipping, strobe lengths under the divider, the identification sequence, read packing, the self-reset on a short rest width, and words left queued after the last beat.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;
  localparam int BEAT_W = 18;

  localparam logic [2:0] A_ID   = 3'd0;
  localparam logic [2:0] A_BEAT = 3'd1;
  localparam logic [2:0] A_TIME = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_PICK = 3'd4;
  localparam logic [2:0] A_FIFO = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_PICK, S_ACT, S_REST, S_WB, S_DONE
  } seq_st_e;

  typedef struct packed {
    logic [3:0]        act_m1;
    logic [5:0]        rest_m1;
    logic [2:0]        div_m1;
    logic [4:0]        pw_m1;
    logic [4:0]        pc_m1;
    logic [BEAT_W-1:0] beats_m1;
    logic              en;
    logic              sel_n;
    logic              run_n;
    logic              dc;
    logic              rd_dir;
    logic              dma;
    logic              swap;
  } cfg_t;
endpackage

// File: rtl/pdisp_fifo.sv
module pdisp_fifo #(
  parameter int DW    = 36,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush_i) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  // R12
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH)) else $error("fifo count above depth");
  // R13
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> empty_o) else $error("fifo not empty after flush");
endmodule

// File: rtl/pdisp_regs.sv
module pdisp_regs
  import pdisp_pkg::*;
#(
  parameter logic [31:0] COMP_CODE = 32'h0000_0C1D,
  parameter logic [15:0] VER_MAJOR = 16'd2,
  parameter logic [15:0] VER_MINOR = 16'd3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        re_i,
  input  logic [2:0]  addr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] fifo_data_i,
  input  logic        fifo_empty_i,
  input  logic        idle_i,
  output cfg_t        cfg_o,
  output logic        srst_o,
  output logic        push_o,
  output logic        pop_o,
  output logic [31:0] rdata_o
);
  cfg_t       cfg;
  logic [1:0] id_ptr;
  logic [31:0] id_val;

  assign cfg_o  = cfg;
  assign srst_o = we_i && (addr_i == A_CTRL) && wdata_i[1];
  assign push_o = we_i && (addr_i == A_FIFO) && (be_i != 4'h0);
  assign pop_o  = re_i && (addr_i == A_FIFO) && !fifo_empty_i;

  always_comb begin
    unique case (id_ptr)
      2'd0:    id_val = 32'h5555_5555;
      2'd1:    id_val = 32'hAAAA_AAAA;
      2'd2:    id_val = COMP_CODE;
      default: id_val = {VER_MAJOR, VER_MINOR};
    endcase
  end

  always_comb begin
    unique case (addr_i)
      A_ID:    rdata_o = id_val;
      A_BEAT:  rdata_o = {{(32-BEAT_W){1'b0}}, cfg.beats_m1};
      A_TIME:  rdata_o = {13'b0, cfg.div_m1, 2'b0, cfg.rest_m1, 4'b0, cfg.act_m1};
      A_CTRL:  rdata_o = {23'b0, idle_i, cfg.swap, cfg.dma, cfg.rd_dir, cfg.dc,
                          cfg.run_n, cfg.sel_n, 1'b0, cfg.en};
      A_PICK:  rdata_o = {22'b0, cfg.pc_m1, cfg.pw_m1};
      A_FIFO:  rdata_o = fifo_empty_i ? 32'h0 : fifo_data_i;
      default: rdata_o = 32'h0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg          <= '0;
      cfg.rest_m1  <= 6'd2;
      cfg.pw_m1    <= 5'd7;
      cfg.pc_m1    <= 5'd3;
      cfg.sel_n    <= 1'b1;
      cfg.run_n    <= 1'b1;
      id_ptr       <= 2'd0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          A_ID:   if (wdata_i == 32'h0) id_ptr <= 2'd0;
          A_BEAT: cfg.beats_m1 <= wdata_i[BEAT_W-1:0];
          A_TIME: begin
            cfg.act_m1  <= wdata_i[3:0];
            cfg.rest_m1 <= wdata_i[13:8];
            cfg.div_m1  <= wdata_i[18:16];
          end
          A_CTRL: begin
            cfg.en     <= wdata_i[0];
            cfg.sel_n  <= wdata_i[2];
            cfg.run_n  <= wdata_i[3];
            cfg.dc     <= wdata_i[4];
            cfg.rd_dir <= wdata_i[5];
            cfg.dma    <= wdata_i[6];
            cfg.swap   <= wdata_i[7];
          end
          A_PICK: begin
            cfg.pw_m1 <= wdata_i[4:0];
            cfg.pc_m1 <= wdata_i[9:5];
          end
          default: ;
        endcase
      end
      if (re_i && (addr_i == A_ID) && (id_ptr != 2'd3)) id_ptr <= id_ptr + 2'd1;
    end
  end
endmodule

// File: rtl/pdisp_seq.sv
module pdisp_seq
  import pdisp_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             srst_i,
  input  logic             fifo_empty_i,
  input  logic             fifo_full_i,
  input  logic [35:0]      fifo_rdata_i,
  output logic             fifo_pop_o,
  output logic             fifo_push_o,
  output logic [31:0]      acc_o,
  output logic             self_rst_o,
  output logic             idle_o,
  output logic             wr_no,
  output logic             rd_no,
  output logic [BUS_W-1:0] dout_o,
  input  logic [BUS_W-1:0] din_i
);
  seq_st_e           st;
  logic [BEAT_W-1:0] beat_left;
  logic [31:0]       cur_word, acc;
  logic [3:0]        cur_be;
  logic [4:0]        lane;
  logic [5:0]        ph;
  logic [2:0]        dcnt;
  logic              fin;
  logic [BUS_W-1:0]  dout_q;

  logic        go, tick, lane_en, timed;
  logic [5:0]  pw;
  logic [4:0]  pos;
  logic [10:0] off;
  logic [31:0] mask32, lane_data;

  assign go     = cfg_i.en && !cfg_i.sel_n && !cfg_i.run_n;
  assign timed  = (st == S_ACT) || (st == S_REST);
  assign tick   = timed && (dcnt == cfg_i.div_m1);
  assign pw     = {1'b0, cfg_i.pw_m1} + 6'd1;
  assign pos    = cfg_i.swap ? (cfg_i.pc_m1 - lane) : lane;
  assign off    = 11'(pos) * 11'(pw);
  assign mask32 = (pw >= 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << pw) - 32'd1);
  assign lane_data = cur_word >> off;
  assign lane_en   = (off < 11'd32) ? cur_be[off[4:3]] : 1'b0;

  assign self_rst_o  = (st == S_IDLE) && go && !srst_i && (cfg_i.rest_m1 < 6'd2);
  assign fifo_pop_o  = (st == S_FETCH) && go && !srst_i && !cfg_i.rd_dir && !fifo_empty_i;
  assign fifo_push_o = (st == S_WB) && go && !srst_i && !fifo_full_i;
  assign acc_o       = acc;
  assign idle_o      = (st == S_IDLE) || (st == S_DONE);
  assign wr_no       = !((st == S_ACT) && !cfg_i.rd_dir);
  assign rd_no       = !((st == S_ACT) && cfg_i.rd_dir);
  assign dout_o      = dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dcnt <= '0;
    else if (!timed || srst_i || !go) dcnt <= '0;
    else dcnt <= tick ? 3'd0 : dcnt + 3'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; beat_left <= '0; cur_word <= '0; cur_be <= '0;
      acc <= '0; lane <= '0; ph <= '0; fin <= 1'b0; dout_q <= '0;
    end else if (srst_i || !go) begin
      st <= S_IDLE; lane <= '0; ph <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (!self_rst_o) begin
          beat_left <= cfg_i.beats_m1;
          fin       <= 1'b0;
          st        <= S_FETCH;
        end
        S_FETCH: begin
          lane <= '0;
          if (cfg_i.rd_dir) begin
            acc <= '0; st <= S_PICK;
          end else if (!fifo_empty_i) begin
            cur_word <= fifo_rdata_i[31:0];
            cur_be   <= fifo_rdata_i[35:32];
            st       <= S_PICK;
          end
        end
        S_PICK: begin
          if (cfg_i.rd_dir || lane_en) begin
            dout_q <= BUS_W'(lane_data & mask32);
            ph     <= '0;
            st     <= S_ACT;
          end else if (lane == cfg_i.pc_m1) begin
            st <= S_FETCH;
          end else begin
            lane <= lane + 5'd1;
          end
        end
        S_ACT: if (tick) begin
          if (ph == {2'b0, cfg_i.act_m1}) begin
            ph <= '0;
            st <= S_REST;
            if (cfg_i.rd_dir && off < 11'd32)
              acc <= acc | ((32'(din_i) & mask32) << off);
          end else ph <= ph + 6'd1;
        end
        S_REST: if (tick) begin
          if (ph == cfg_i.rest_m1) begin
            ph <= '0;
            if (beat_left == '0) begin
              fin <= 1'b1;
              st  <= cfg_i.rd_dir ? S_WB : S_DONE;
            end else begin
              beat_left <= beat_left - 1'b1;
              if (lane == cfg_i.pc_m1) begin
                lane <= '0;
                st   <= cfg_i.rd_dir ? S_WB : S_FETCH;
              end else begin
                lane <= lane + 5'd1;
                st   <= S_PICK;
              end
            end
          end else ph <= ph + 6'd1;
        end
        S_WB:    if (!fifo_full_i) st <= fin ? S_DONE : S_FETCH;
        S_DONE:  ;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!wr_no && !rd_no)) else $error("both strobes low");
  // R8
  strobe_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no || !rd_no) |-> !cfg_i.sel_n) else $error("strobe without chip select");
  // R3
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no && $past(!wr_no)) |-> $stable(dout_o)) else $error("data moved under strobe");
  // R7
  beats_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_DONE) |-> (beat_left == '0)) else $error("finished with beats left");
endmodule

// File: rtl/pdisp_tx.sv
module pdisp_tx
  import pdisp_pkg::*;
#(
  parameter int          BUS_W      = 16,
  parameter int          FIFO_DEPTH = 8,
  parameter logic [31:0] COMP_CODE  = 32'h0000_0C1D,
  parameter logic [15:0] VER_MAJOR  = 16'd2,
  parameter logic [15:0] VER_MINOR  = 16'd3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [3:0]       reg_be_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             bus_cs_no,
  output logic             bus_dc_o,
  output logic             bus_wr_no,
  output logic             bus_rd_no,
  output logic             bus_oe_o,
  output logic [BUS_W-1:0] bus_dout_o,
  input  logic [BUS_W-1:0] bus_din_i,
  output logic             dma_req_o
);
  cfg_t        cfg;
  logic        srst, self_rst, flush, idle;
  logic        reg_push, reg_pop, eng_push, eng_pop;
  logic        f_push, f_pop, f_empty, f_full;
  logic [35:0] f_wdata, f_rdata;
  logic [31:0] acc;

  pdisp_regs #(.COMP_CODE(COMP_CODE), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i), .be_i(reg_be_i),
    .wdata_i(reg_wdata_i), .fifo_data_i(f_rdata[31:0]), .fifo_empty_i(f_empty),
    .idle_i(idle), .cfg_o(cfg), .srst_o(srst), .push_o(reg_push), .pop_o(reg_pop),
    .rdata_o(reg_rdata_o)
  );

  // engine side wins a same-cycle queue access
  assign flush   = srst || self_rst;
  assign f_push  = eng_push || reg_push;
  assign f_pop   = eng_pop || reg_pop;
  assign f_wdata = eng_push ? {4'hF, acc} : {reg_be_i, reg_wdata_i};

  pdisp_fifo #(.DW(36), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(f_push), .wdata_i(f_wdata),
    .pop_i(f_pop), .rdata_o(f_rdata), .empty_o(f_empty), .full_o(f_full)
  );

  pdisp_seq #(.BUS_W(BUS_W)) u_seq (
    .clk_i, .rst_ni, .cfg_i(cfg), .srst_i(srst),
    .fifo_empty_i(f_empty), .fifo_full_i(f_full), .fifo_rdata_i(f_rdata),
    .fifo_pop_o(eng_pop), .fifo_push_o(eng_push), .acc_o(acc),
    .self_rst_o(self_rst), .idle_o(idle),
    .wr_no(bus_wr_no), .rd_no(bus_rd_no), .dout_o(bus_dout_o), .din_i(bus_din_i)
  );

  assign bus_cs_no = cfg.sel_n;
  assign bus_dc_o  = cfg.dc;
  assign bus_oe_o  = !cfg.sel_n && !cfg.rd_dir;
  assign dma_req_o = cfg.en && cfg.dma && !cfg.rd_dir && !f_full;

  // R12
  dma_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> !f_full) else $error("dma request with full queue");
endmodule

// File: tb/tb_pdisp_tx.sv
`timescale 1ns/1ps
module tb_pdisp_tx;
  localparam logic [2:0] A_ID = 0, A_BEAT = 1, A_TIME = 2, A_CTRL = 3, A_PICK = 4, A_FIFO = 5;

  logic clk_i = 0, rst_ni = 0;
  logic reg_we_i = 0, reg_re_i = 0;
  logic [2:0] reg_addr_i = 0;
  logic [3:0] reg_be_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic bus_cs_no, bus_dc_o, bus_wr_no, bus_rd_no, bus_oe_o, dma_req_o;
  logic [15:0] bus_dout_o, bus_din_i;
  int rd_idx = 0;

  always #2 clk_i = ~clk_i;
  assign bus_din_i = 16'hA000 + 16'(rd_idx);
  always @(posedge bus_rd_no) rd_idx++;

  pdisp_tx dut (.*);

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // strobe monitor
  int nb = 0, nrd = 0, cur_low = 0, cur_high = 0;
  logic [15:0] bval [64];
  int blen [64];
  int bgap [64];
  logic pw = 1, pr = 1;
  always @(negedge clk_i) begin
    if (!bus_wr_no) begin
      if (pw && nb < 64) begin bval[nb] = bus_dout_o; bgap[nb] = cur_high; nb++; cur_low = 0; end
      cur_low++;
      if (nb > 0) blen[nb-1] = cur_low;
    end else begin
      if (!pw) cur_high = 0;
      cur_high++;
    end
    if (!bus_rd_no && pr) nrd++;
    pw = bus_wr_no; pr = bus_rd_no;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic clr_mon();
    @(posedge clk_i); #1; nb = 0; nrd = 0; rd_idx = 0; cur_high = 0;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d; reg_be_i = be;
    @(negedge clk_i); reg_we_i = 0; reg_be_i = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i); reg_re_i = 1; reg_addr_i = a; #1 d = reg_rdata_o;
    @(negedge clk_i); reg_re_i = 0;
  endtask

  function automatic logic [31:0] ctrl(bit en, bit sel_n, bit run_n, bit dc, bit rd, bit dma, bit swp, bit srst = 0);
    return {24'b0, swp, dma, rd, dc, run_n, sel_n, srst, en};
  endfunction

  task automatic prep(input logic [31:0] pick, input logic [31:0] tim, input logic [31:0] beats);
    reg_wr(A_CTRL, ctrl(0, 1, 1, 0, 0, 0, 0, 1));
    reg_wr(A_PICK, pick);
    reg_wr(A_TIME, tim);
    reg_wr(A_BEAT, beats);
    clr_mon();
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 3000; i++) begin
      reg_rd(A_CTRL, v);
      if (v[8]) break;
    end
  endtask

  task automatic stop();
    reg_wr(A_CTRL, ctrl(0, 1, 1, 0, 0, 0, 0));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(bus_cs_no && bus_wr_no && bus_rd_no, "R1 strobes", {bus_cs_no, bus_wr_no, bus_rd_no}, 3'b111);
    chk(!dma_req_o, "R1 dma", dma_req_o, 0);
    reg_rd(A_CTRL, v);
    chk(v == 32'h10C, "R1 ctrl", v, 32'h10C);
  endtask

  task automatic t_id();
    logic [31:0] v;
    reg_wr(A_ID, 0);
    reg_rd(A_ID, v); chk(v == 32'h5555_5555, "R2 first", v, 32'h5555_5555);
    reg_rd(A_ID, v); chk(v == 32'hAAAA_AAAA, "R2 second", v, 32'hAAAA_AAAA);
    reg_rd(A_ID, v); chk(v == 32'h0000_0C1D, "R2 comp", v, 32'h0000_0C1D);
    reg_rd(A_ID, v); chk(v == 32'h0002_0003, "R2 version", v, 32'h0002_0003);
  endtask

  task automatic t_write8();
    logic [7:0] exp [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    prep({22'b0, 5'd3, 5'd7}, 32'h0000_0201, 3);
    reg_wr(A_FIFO, 32'h4433_2211);
    reg_wr(A_CTRL, ctrl(1, 0, 0, 1, 0, 0, 0));
    wait_idle();
    chk(nb == 4, "R4 beat count 8b", nb, 4);
    for (int i = 0; i < 4; i++) begin
      chk(bval[i] == 16'(exp[i]), "R4 lane order 8b", bval[i], exp[i]);
      chk(blen[i] == 2, "R3 active width", blen[i], 2);
    end
    for (int i = 1; i < 4; i++) chk(bgap[i] >= 3 && bgap[i] <= 6, "R3 rest width", bgap[i], 3);
    chk(!bus_cs_no && bus_dc_o && bus_oe_o, "R8 cs/dc/oe", {bus_cs_no, bus_dc_o, bus_oe_o}, 3'b011);
    stop();
    chk(bus_cs_no, "R8 cs released", bus_cs_no, 1);
  endtask

  task automatic t_write16_div();
    logic [15:0] exp [4] = '{16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD};
    prep({22'b0, 5'd1, 5'd15}, 32'h0002_0302, 3);
    reg_wr(A_FIFO, 32'hBBBB_AAAA);
    reg_wr(A_FIFO, 32'hDDDD_CCCC);
    reg_wr(A_CTRL, ctrl(1, 0, 0, 0, 0, 0, 0));
    wait_idle();
    chk(nb == 4, "R4 beat count 16b", nb, 4);
    for (int i = 0; i < 4; i++) begin
      chk(bval[i] == exp[i], "R4 lane order 16b", bval[i], exp[i]);
      chk(blen[i] == 9, "R3 divided active", blen[i], 9);
    end
    for (int i = 1; i < 4; i++) chk(bgap[i] >= 12 && bgap[i] <= 15, "R3 divided rest", bgap[i], 12);
    chk(!bus_dc_o, "R8 command mode", bus_dc_o, 0);
    stop();
  endtask

  task automatic t_swap();
    logic [7:0] exp [4] = '{8'hDD, 8'hCC, 8'hBB, 8'hAA};
    prep({22'b0, 5'd3, 5'd7}, 32'h0000_0200, 3);
    reg_wr(A_FIFO, 32'hDDCC_BBAA);
    reg_wr(A_CTRL, ctrl(1, 0, 0, 1, 0, 0, 1));
    wait_idle();
    chk(nb == 4, "R5 beat count", nb, 4);
    for (int i = 0; i < 4; i++) chk(bval[i] == 16'(exp[i]), "R5 swapped order", bval[i], exp[i]);
    stop();
  endtask

  task automatic t_bytes();
    prep({22'b0, 5'd3, 5'd7}, 32'h0000_0200, 1);
    reg_wr(A_FIFO, 32'h4433_2211, 4'b0101);
    reg_wr(A_CTRL, ctrl(1, 0, 0, 1, 0, 0, 0));
    wait_idle();
    chk(nb == 2, "R6 skipped lanes 8b", nb, 2);
    chk(bval[0] == 16'h11 && bval[1] == 16'h33, "R6 kept lanes", {bval[0], bval[1]}, 32'h0011_0033);
    stop();
    prep({22'b0, 5'd1, 5'd15}, 32'h0000_0200, 0);
    reg_wr(A_FIFO, 32'h0000_BBAA, 4'b0011);
    reg_wr(A_CTRL, ctrl(1, 0, 0, 1, 0, 0, 0));
    wait_idle();
    chk(nb == 1 && bval[0] == 16'hBBAA, "R6 16b half write", bval[0], 16'hBBAA);
    stop();
  endtask

  task automatic t_count();
    logic [31:0] v;
    prep({22'b0, 5'd3, 5'd7}, 32'h0000_0201, 4);
    reg_wr(A_FIFO, 32'h0302_0100);
    reg_wr(A_FIFO, 32'h0706_0504);
    reg_wr(A_FIFO, 32'h0B0A_0908);
    reg_wr(A_CTRL, ctrl(1, 0, 0, 1, 0, 0, 0));
    repeat (3) @(negedge clk_i);
    reg_rd(A_CTRL, v);
    chk(!v[8], "R9 busy while running", v[8], 0);
    wait_idle();
    reg_rd(A_CTRL, v);
    chk(v[8], "R9 idle when finished", v[8], 1);
    chk(nb == 5, "R7 exact beat count", nb, 5);
    for (int i = 0; i < 5; i++) chk(bval[i] == 16'(i), "R7 beat data", bval[i], i);
    repeat (20) @(negedge clk_i);
    chk(nb == 5, "R7 no extra beats", nb, 5);
    reg_rd(A_FIFO, v); chk(v == 32'h0B0A_0908, "R7 leftover word", v, 32'h0B0A_0908);
    reg_rd(A_FIFO, v); chk(v == 32'h0, "R7 queue then empty", v, 0);
    stop();
  endtask

  task automatic t_read();
    logic [31:0] v;
    prep({22'b0, 5'd1, 5'd15}, 32'h0000_0201, 3);
    reg_wr(A_CTRL, ctrl(1, 0, 0, 1, 1, 0, 0));
    wait_idle();
    chk(nrd == 4 && nb == 0, "R11 read strobes", {nrd[15:0], nb[15:0]}, 32'h0004_0000);
    chk(!bus_oe_o, "R11 bus not driven", bus_oe_o, 0);
    reg_rd(A_FIFO, v); chk(v == 32'hA001_A000, "R11 first word", v, 32'hA001_A000);
    reg_rd(A_FIFO, v); chk(v == 32'hA003_A002, "R11 second word", v, 32'hA003_A002);
    stop();
  endtask

  task automatic t_selfrst();
    logic [31:0] v;
    prep({22'b0, 5'd3, 5'd7}, 32'h0000_0100, 0);
    reg_wr(A_FIFO, 32'h0000_005A);
    reg_wr(A_CTRL, ctrl(1, 0, 0, 1, 0, 0, 0));
    repeat (10) @(negedge clk_i);
    chk(nb == 0, "R10 no strobe on short rest", nb, 0);
    reg_rd(A_CTRL, v); chk(v[8], "R10 stays idle", v[8], 1);
    stop();
    reg_wr(A_TIME, 32'h0000_0200);
    reg_wr(A_CTRL, ctrl(1, 0, 0, 1, 0, 0, 0));
    repeat (15) @(negedge clk_i);
    chk(nb == 0, "R10 queue was flushed", nb, 0);
    reg_rd(A_CTRL, v); chk(!v[8], "R10 waits for data", v[8], 0);
    reg_wr(A_FIFO, 32'h0000_005A);
    wait_idle();
    chk(nb == 1 && bval[0] == 16'h5A, "R10 resumes", bval[0], 16'h5A);
    stop();
  endtask

  task automatic t_dma();
    prep({22'b0, 5'd3, 5'd7}, 32'h0000_0200, 0);
    reg_wr(A_CTRL, ctrl(0, 1, 1, 0, 0, 1, 0));
    chk(!dma_req_o, "R13 dma off when disabled", dma_req_o, 0);
    reg_wr(A_CTRL, ctrl(1, 1, 1, 0, 0, 1, 0));
    chk(dma_req_o, "R12 dma when room", dma_req_o, 1);
    for (int i = 0; i < 8; i++) reg_wr(A_FIFO, 32'(i));
    chk(!dma_req_o, "R12 dma drops when full", dma_req_o, 0);
    reg_wr(A_CTRL, ctrl(1, 1, 1, 0, 0, 1, 0, 1));
    chk(dma_req_o, "R13 flush frees queue", dma_req_o, 1);
    stop();
    prep({22'b0, 5'd3, 5'd7}, 32'h0000_0200, 0);
    reg_wr(A_FIFO, 32'h0000_0077);
    reg_wr(A_CTRL, ctrl(0, 0, 0, 1, 0, 0, 0));
    repeat (20) @(negedge clk_i);
    chk(nb == 0, "R13 no strobe when disabled", nb, 0);
    stop();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_id();
    t_write8();
    t_write16_div();
    t_swap();
    t_bytes();
    t_count();
    t_read();
    t_selfrst();
    t_dma();
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule